// File: doc/BRIEF.md
# Dual Parallel-Port GPIO Register Block

This block exposes forty-eight general-purpose lines through a small byte-wide register window of sixteen addresses. The lines form two identical groups. Each group has three 8-bit ports and one mode register. The mode register sets which fields are inputs. Ports A and B switch direction as whole bytes. Port C switches direction as two independent nibbles. Each pin appears as three vectors: an input, an output value and an output enable. An external pad ring combines them into bidirectional pins.

The bus is synchronous. A write takes effect on the clock edge at which `wr_en` is high. Read data is combinational: it is valid while `rd_en` and `addr` are held, and any side effect of the read lands on the same clock edge.

One interrupt output watches line 3 of port C in each group for rising edges. Two bus accesses at address 0xB control it. A write enables edge capture and a read disables it. A write at 0xF clears the pending interrupt. Software sets the block up by writing a mode word (bit 7 set) to each mode register, then writing zero to every data port.

Top module: `dual_pio_block`

## Requirements
- R1: After reset every line is an output (`pin_oe` all ones), `pin_out` is all zeros, interrupt capture is disabled and `irq` is low.
- R2: Group g (0 or 1) has port A at address 4g, port B at 4g+1, port C at 4g+2 and its mode register at 4g+3. Bit b of port p in group g is line 24g+8p+b. A data write loads that port's output latch, and `pin_out` always shows the latch, whatever the direction.
- R3: A mode-register write with bit 7 set updates the direction fields. Bit 4 set makes port A input. Bit 1 set makes port B input. Bit 0 set makes port C bits 3:0 input. Bit 3 set makes port C bits 7:4 input. A cleared bit means output, and `pin_oe` is high exactly on the output lines.
- R4: A mode-register write with bit 7 set also clears all three output latches of that group. The other group is left unchanged.
- R5: A mode-register write with bit 7 clear has no effect on direction, latches or the value read back.
- R6: A data-port read returns `pin_in` on input bits and the output latch on output bits.
- R7: A mode-register read returns {1, 0, 0, A_in, Chigh_in, 0, B_in, Clow_in}. Addresses 8 to 15 read as zero, and writes there change no port state.
- R8: A write at address 0xB enables interrupt capture. A read at address 0xB disables it.
- R9: While capture is enabled, a low-to-high change on line 19 or line 43 (port C bit 3 of either group) sets the pending flag, and `irq` reflects it from the next clock edge. Falling edges and changes on any other line do not set it.
- R10: Edges that occur while capture is disabled are not recorded, and enabling afterwards does not raise `irq` for them.
- R11: Once set, the pending flag holds until a write at 0xF. Disabling capture does not clear it. An edge in the same cycle as the clearing write leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 4 | Byte address within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| pin_in | input | 48 | Sampled pin levels |
| pin_out | output | 48 | Output latch values |
| pin_oe | output | 48 | Output enable per line, high means driven |
| irq | output | 1 | Level interrupt, high while pending |

## Verification
The bench exercises the split port C nibbles with different directions in each half. A design that treated port C as one field would return latch bits where pin levels belong, or would drive lines that should float. It checks that a mode write clears only its own group's latches and that a mode write with bit 7 clear is ignored; a decode error would wipe the wrong group or change directions. On the interrupt side, the bench raises edges while capture is disabled and then enables it; a design that captured these edges would assert `irq` spuriously. It also lands an edge in the same cycle as the clear, and disables capture with a flag already pending; a design that got either case wrong would lose a real interrupt.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PORT_W      = 8;
    localparam int PORTS       = 3;
    localparam int GROUP_LINES = PORT_W * PORTS;

    // mode word bit positions
    localparam int MODE_FLAG = 7;
    localparam int A_IN_BIT  = 4;
    localparam int CH_IN_BIT = 3;
    localparam int B_IN_BIT  = 1;
    localparam int CL_IN_BIT = 0;

    localparam logic [3:0] IRQ_EN_ADDR  = 4'hB;
    localparam logic [3:0] IRQ_CLR_ADDR = 4'hF;

    typedef enum logic [1:0] {
        SLOT_A    = 2'd0,
        SLOT_B    = 2'd1,
        SLOT_C    = 2'd2,
        SLOT_MODE = 2'd3
    } slot_e;

    typedef struct packed {
        logic a_in;
        logic b_in;
        logic cl_in;
        logic ch_in;
    } dir_t;

    function automatic dir_t decode_mode(input logic [PORT_W-1:0] w);
        dir_t d;
        d.a_in  = w[A_IN_BIT];
        d.b_in  = w[B_IN_BIT];
        d.cl_in = w[CL_IN_BIT];
        d.ch_in = w[CH_IN_BIT];
        return d;
    endfunction

    function automatic logic [PORT_W-1:0] encode_mode(input dir_t d);
        logic [PORT_W-1:0] w;
        w            = '0;
        w[MODE_FLAG] = 1'b1;
        w[A_IN_BIT]  = d.a_in;
        w[B_IN_BIT]  = d.b_in;
        w[CL_IN_BIT] = d.cl_in;
        w[CH_IN_BIT] = d.ch_in;
        return w;
    endfunction

    // per-port input mask: 1 = line is an input
    function automatic logic [PORT_W-1:0] input_mask(input dir_t d, input int p);
        logic [PORT_W-1:0] m;
        case (p)
            0:       m = {PORT_W{d.a_in}};
            1:       m = {PORT_W{d.b_in}};
            default: m = {{(PORT_W/2){d.ch_in}}, {(PORT_W/2){d.cl_in}}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pio_group.sv
module pio_group
    import pio_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   sel,
    input  slot_e                  slot,
    input  logic [PORT_W-1:0]      wdata,
    input  logic [GROUP_LINES-1:0] pin_in,
    output logic [GROUP_LINES-1:0] pin_out,
    output logic [GROUP_LINES-1:0] pin_oe,
    output logic [PORT_W-1:0]      rdata
);

    logic [PORT_W-1:0] latch [PORTS];
    logic [PORT_W-1:0] view  [PORTS];
    dir_t              dir;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir <= '0;
            for (int p = 0; p < PORTS; p++) latch[p] <= '0;
        end else if (wr_en && sel) begin
            case (slot)
                SLOT_A: latch[0] <= wdata;
                SLOT_B: latch[1] <= wdata;
                SLOT_C: latch[2] <= wdata;
                default: begin
                    if (wdata[MODE_FLAG]) begin
                        dir <= decode_mode(wdata);
                        for (int p = 0; p < PORTS; p++) latch[p] <= '0;
                    end
                end
            endcase
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic [PORT_W-1:0] imask;
        assign imask                   = input_mask(dir, p);
        assign pin_out[p*PORT_W +: PORT_W] = latch[p];
        assign pin_oe [p*PORT_W +: PORT_W] = ~imask;
        assign view[p] = (pin_in[p*PORT_W +: PORT_W] & imask) | (latch[p] & ~imask);
    end

    always_comb begin
        case (slot)
            SLOT_A:  rdata = view[0];
            SLOT_B:  rdata = view[1];
            SLOT_C:  rdata = view[2];
            default: rdata = encode_mode(dir);
        endcase
    end

endmodule

// File: rtl/pio_irq.sv
module pio_irq #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             pend_clr,
    input  logic [LINES-1:0] watch,
    output logic             irq,
    output logic             enabled
);

    logic [LINES-1:0] prev;
    logic             pending;
    logic             rise;

    assign rise = |(watch & ~prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= '0;
            pending <= 1'b0;
            enabled <= 1'b0;
        end else begin
            prev <= watch;
            if (en_set)      enabled <= 1'b1;
            else if (en_clr) enabled <= 1'b0;
            // a fresh edge wins over a simultaneous clear
            pending <= (pending && !pend_clr) || (enabled && rise);
        end
    end

    assign irq = pending;

endmodule

// File: rtl/dual_pio_block.sv
module dual_pio_block
    import pio_pkg::*;
#(
    parameter int GROUPS  = 2,
    parameter int ADDR_W  = 4,
    parameter int IRQ_BIT = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [PORT_W-1:0]               wdata,
    output logic [PORT_W-1:0]               rdata,
    input  logic [GROUPS*GROUP_LINES-1:0]   pin_in,
    output logic [GROUPS*GROUP_LINES-1:0]   pin_out,
    output logic [GROUPS*GROUP_LINES-1:0]   pin_oe,
    output logic                            irq
);

    localparam int GSEL_W   = ADDR_W - 2;
    localparam int C_OFFSET = 2 * PORT_W;

    logic [GROUPS-1:0] grp_sel;
    logic [PORT_W-1:0] grp_rd [GROUPS];
    logic [GROUPS-1:0] watch;
    logic              irq_en;
    slot_e             slot;

    assign slot = slot_e'(addr[1:0]);

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_sel[g] = (addr[ADDR_W-1:2] == GSEL_W'(g));
        assign watch[g]   = pin_in[g*GROUP_LINES + C_OFFSET + IRQ_BIT];

        pio_group u_grp (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .sel     (grp_sel[g]),
            .slot    (slot),
            .wdata   (wdata),
            .pin_in  (pin_in [g*GROUP_LINES +: GROUP_LINES]),
            .pin_out (pin_out[g*GROUP_LINES +: GROUP_LINES]),
            .pin_oe  (pin_oe [g*GROUP_LINES +: GROUP_LINES]),
            .rdata   (grp_rd[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int g = 0; g < GROUPS; g++)
            if (grp_sel[g]) rdata = grp_rd[g];
    end

    pio_irq #(.LINES(GROUPS)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .en_set   (wr_en && addr == IRQ_EN_ADDR),
        .en_clr   (rd_en && addr == IRQ_EN_ADDR),
        .pend_clr (wr_en && addr == IRQ_CLR_ADDR),
        .watch    (watch),
        .irq      (irq),
        .enabled  (irq_en)
    );

endmodule

// File: rtl/pio_checker.sv
module pio_checker #(
    parameter int NL = 48
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic [3:0]    addr,
    input logic [7:0]    wdata,
    input logic [NL-1:0] pin_out,
    input logic [NL-1:0] pin_oe,
    input logic          irq,
    input logic          irq_en
);

    logic mode0_set, mode0_plain;
    assign mode0_set   = wr_en && addr == 4'h3 && wdata[7];
    assign mode0_plain = wr_en && addr == 4'h3 && !wdata[7];

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (&pin_oe) && (pin_out == '0) && !irq && !irq_en);

    p_mode_dir_r3: assert property (@(posedge clk) disable iff (rst)
        mode0_set |=> pin_oe[7:0]  == {8{~$past(wdata[4])}}
                   && pin_oe[15:8] == {8{~$past(wdata[1])}});

    p_mode_clear_r4: assert property (@(posedge clk) disable iff (rst)
        mode0_set |=> pin_out[23:0] == '0);

    p_plain_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        mode0_plain |=> $stable(pin_oe) && $stable(pin_out));

    p_enable_on_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 4'hB) |=> irq_en);

    p_enable_off_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == 4'hB) |=> !irq_en);

    p_rise_needs_en_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(irq_en));

    p_pending_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_en && addr == 4'hF)) |=> irq);

endmodule

bind dual_pio_block pio_checker #(.NL(GROUPS*pio_pkg::GROUP_LINES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq),
    .irq_en  (irq_en)
);

// File: tb/sim_dual_pio_block.sv
`timescale 1ns/1ps
module sim_dual_pio_block;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] pin_in = '0;
    logic [47:0] pin_out;
    logic [47:0] pin_oe;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    dual_pio_block u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", pin_oe, '1);
        chk("R1 out after reset", pin_out, '0);
        chk("R1 irq after reset", {47'd0, irq}, 48'd0);
    endtask

    task automatic t_map();
        logic [7:0] d;
        wr(4'h0, 8'h5A); wr(4'h1, 8'hC3); wr(4'h2, 8'h81);
        wr(4'h4, 8'h12); wr(4'h5, 8'h34); wr(4'h6, 8'h56);
        chk("R2 line map", pin_out, 48'h563412_81C35A);
        rd(4'h1, d); chk("R6 read output B0", {40'd0, d}, 48'hC3);
        rd(4'h6, d); chk("R6 read output C1", {40'd0, d}, 48'h56);
    endtask

    task automatic t_dir();
        logic [7:0] d;
        wr(4'h3, 8'h91);  // A0 in, C0 low nibble in
        chk("R3 oe group0", {24'd0, pin_oe[23:0]}, 48'h00F0FF00);
        chk("R4 group0 cleared", {24'd0, pin_out[23:0]}, 48'd0);
        chk("R4 group1 kept", {24'd0, pin_out[47:24]}, 48'h563412);
        rd(4'h3, d); chk("R7 mode read group0", {40'd0, d}, 48'h91);
        wr(4'h0, 8'h77); wr(4'h2, 8'hA0);
        chk("R2 latch drives while input", {40'd0, pin_out[7:0]}, 48'h77);
        pin_in[7:0] = 8'h3C; pin_in[23:16] = 8'h37;
        rd(4'h0, d); chk("R6 read input A0", {40'd0, d}, 48'h3C);
        rd(4'h2, d); chk("R6 split read C0", {40'd0, d}, 48'hA7);
        wr(4'h7, 8'h8A);  // B1 in, C1 high nibble in
        chk("R3 oe group1", {24'd0, pin_oe[47:24]}, 48'h000F00FF);
        chk("R4 group1 cleared", {24'd0, pin_out[47:24]}, 48'd0);
        rd(4'h7, d); chk("R7 mode read group1", {40'd0, d}, 48'h8A);
        pin_in[39:32] = 8'h5E;
        rd(4'h5, d); chk("R6 read input B1", {40'd0, d}, 48'h5E);
    endtask

    task automatic t_ignored();
        logic [7:0]  d;
        logic [47:0] oe_b, out_b;
        oe_b = pin_oe; out_b = pin_out;
        wr(4'h3, 8'h1B);
        chk("R5 oe unchanged", pin_oe, oe_b);
        chk("R5 latches unchanged", pin_out, out_b);
        rd(4'h3, d); chk("R5 mode read unchanged", {40'd0, d}, 48'h91);
        wr(4'h9, 8'hFF);
        chk("R7 high write no effect", pin_out, out_b);
        rd(4'h9, d); chk("R7 high read zero", {40'd0, d}, 48'd0);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        pin_in = '0;
        wr(4'hF, 8'h00); wr(4'hB, 8'h00);
        @(negedge clk); pin_in[19] = 1'b1;
        @(negedge clk); chk("R9 edge on line 19", {47'd0, irq}, 48'd1);
        @(negedge clk); pin_in[19] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 held after line falls", {47'd0, irq}, 48'd1);
        rd(4'hB, d);
        chk("R11 held after disable", {47'd0, irq}, 48'd1);
        wr(4'hF, 8'h00);
        chk("R11 cleared by write", {47'd0, irq}, 48'd0);
        @(negedge clk); pin_in[43] = 1'b1;
        @(negedge clk); chk("R10 edge while disabled", {47'd0, irq}, 48'd0);
        wr(4'hB, 8'h00);
        @(negedge clk); chk("R10 no late capture", {47'd0, irq}, 48'd0);
        @(negedge clk); pin_in[43] = 1'b0;
        @(negedge clk); chk("R9 falling edge ignored", {47'd0, irq}, 48'd0);
        pin_in[18] = 1'b1; pin_in[20] = 1'b1; pin_in[11] = 1'b1; pin_in[42] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R9 other lines ignored", {47'd0, irq}, 48'd0);
        pin_in[43] = 1'b1;
        @(negedge clk); chk("R9 edge on line 43", {47'd0, irq}, 48'd1);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'hF; pin_in[19] = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        chk("R11 edge beats clear", {47'd0, irq}, 48'd1);
        wr(4'hF, 8'h00);
        chk("R11 final clear", {47'd0, irq}, 48'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_map();
        t_dir();
        t_ignored();
        t_irq();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule